// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Per-Pin Interrupt Triggering

This block is one general-purpose I/O port. Each pin has its own direction bit, which selects whether the port drives the pin or only observes it. Software changes output levels through separate strobe registers that set, clear or invert only the bits written as 1. Any combination of pins can therefore change in one bus access, and the other pins are not disturbed. A direct data write that replaces all output levels at once is also available.

Every pin can raise an interrupt. The enable mask is changed through its own set and clear addresses. Each pin is either level triggered or edge triggered. An edge-triggered pin reacts to rising edges only or to both edges, selected per pin. Input pins are resynchronised through two flops before any use. Output pins take their interrupt source from the value software last wrote, so software can raise an interrupt on them by writing the data value. Edge events are latched per pin until software writes a 1 for that pin to the clear address. A single interrupt line is the OR of every enabled, active pin.

Top module: `gpio_irq_port`

## Requirements
- R1: The direction register sits at address 0; bit i = 1 makes pin i an output, and `pin_oe` follows it on the clock after the write. It reads back from address 0 and resets to all zeros (all pins inputs).
- R2: A write to address 2 sets to 1 every output level bit whose write-data bit is 1. Bits written 0 keep their value, and outputs change only on a write to addresses 1 to 4. The output levels `pin_out` reset to zero.
- R3: A write to address 3 forces to 0 every output level bit written as 1, and a write to address 4 inverts every output level bit written as 1. Bits written 0 keep their value.
- R4: Address 1 returns, per pin, the output level for output pins and the input level for input pins. An input change becomes visible in the second cycle after it is applied. Addresses 2, 3 and 4 return the same value. A write to address 1 replaces all output levels.
- R5: A write to address 5 sets the enable-mask bits written as 1, and a write to address 6 clears the mask bits written as 1. Both addresses read back the mask, which resets to zero.
- R6: The trigger register at address 7 selects per pin level (0) or edge (1) triggering. A level-triggered, enabled pin holds `irq` high exactly while its source is 1, and nothing is latched.
- R7: For an edge-triggered pin whose both-edges bit (address 8) is 0, a 0-to-1 transition of the source latches a pending flag. A 1-to-0 transition does not. An input edge reaches `irq` in the third cycle after it is applied.
- R8: For an edge-triggered pin whose both-edges bit (address 8) is 1, transitions in either direction latch the pending flag.
- R9: A pending flag stays set until a write to address 3 has a 1 in that bit. If an edge event and that clearing write fall in the same cycle, the clear wins.
- R10: For output pins the interrupt source is the written output level, not the pin input. An output level change caused by software triggers that pin like an input edge or level.
- R11: `irq` is the OR over all pins of (enable mask AND active). Active means the pending flag for edge pins and the source for level pins. A masked pin keeps its pending flag, and `irq` rises once the mask is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| pin_in | input | 16 | Pin levels seen from outside |
| pin_out | output | 16 | Output levels driven to the pins |
| pin_oe | output | 16 | Per-pin output enable (direction) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the interrupt corner cases. A level pin dropping must release `irq`, and a design that latched level events would keep it high. A rising-only pin must ignore the falling edge, and both-edge mode must not. The clearing write is placed in the exact cycle a synchronised edge arrives, so a design that let the event win over the clear would leave `irq` asserted. A pending flag that is masked must survive and reappear when the mask is set, and software writes to an output pin must raise its interrupt, which a design that watched only `pin_in` would miss. The set, clear and toggle strobes use mixed bit patterns, so a strobe that disturbed bits written as 0 shows up as a wrong output level on the next clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_DIR   = 4'd0,
        RA_DATA  = 4'd1,
        RA_SET   = 4'd2,
        RA_CLR   = 4'd3,
        RA_TGL   = 4'd4,
        RA_MSET  = 4'd5,
        RA_MCLR  = 4'd6,
        RA_TRIG  = 4'd7,
        RA_BOTH  = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic dir;
        logic data;
        logic set;
        logic clr;
        logic tgl;
        logic mset;
        logic mclr;
        logic trig;
        logic both;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic en, input logic [ADDR_W-1:0] addr);
        wr_strobe_t s;
        s = '0;
        if (en) begin
            case (reg_addr_e'(addr))
                RA_DIR:  s.dir  = 1'b1;
                RA_DATA: s.data = 1'b1;
                RA_SET:  s.set  = 1'b1;
                RA_CLR:  s.clr  = 1'b1;
                RA_TGL:  s.tgl  = 1'b1;
                RA_MSET: s.mset = 1'b1;
                RA_MCLR: s.mclr = 1'b1;
                RA_TRIG: s.trig = 1'b1;
                RA_BOTH: s.both = 1'b1;
                default: s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_strobe_t       stb,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] trig_q,
    output logic [WIDTH-1:0] both_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            out_q  <= '0;
            mask_q <= '0;
            trig_q <= '0;
            both_q <= '0;
        end else begin
            if (stb.dir)  dir_q  <= wdata;
            if (stb.trig) trig_q <= wdata;
            if (stb.both) both_q <= wdata;

            if (stb.data)     out_q <= wdata;
            else if (stb.clr) out_q <= out_q & ~wdata;
            else if (stb.set) out_q <= out_q | wdata;
            else if (stb.tgl) out_q <= out_q ^ wdata;

            if (stb.mclr)      mask_q <= mask_q & ~wdata;
            else if (stb.mset) mask_q <= mask_q | wdata;
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] src,
    input  logic [WIDTH-1:0] trig,
    input  logic [WIDTH-1:0] both,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] clr_pend,
    output logic             irq
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] active;

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_pin
            logic rise, fall, event_hit;
            assign rise      = src[g] & ~prev_q[g];
            assign fall      = ~src[g] & prev_q[g];
            assign event_hit = trig[g] & (rise | (both[g] & fall));

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q[g] <= 1'b0;
                    pend_q[g] <= 1'b0;
                end else begin
                    prev_q[g] <= src[g];
                    if (clr_pend[g])    pend_q[g] <= 1'b0;
                    else if (event_hit) pend_q[g] <= 1'b1;
                end
            end

            assign active[g] = trig[g] ? pend_q[g] : src[g];
        end
    endgenerate

    assign irq = |(active & mask);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq
);
    wr_strobe_t       stb;
    logic [WIDTH-1:0] dir_q, out_q, mask_q, trig_q, both_q;
    logic [WIDTH-1:0] in_sync, src, clr_pend;

    assign stb = decode_write(bus_sel & bus_wr, bus_addr);

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .stb    (stb),
        .wdata  (bus_wdata),
        .dir_q  (dir_q),
        .out_q  (out_q),
        .mask_q (mask_q),
        .trig_q (trig_q),
        .both_q (both_q)
    );

    // Output pins source their own written level; input pins the synchronised pin.
    assign src      = (dir_q & out_q) | (~dir_q & in_sync);
    assign clr_pend = stb.clr ? bus_wdata : '0;

    gpio_irq_detect #(.WIDTH(WIDTH)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .trig     (trig_q),
        .both     (both_q),
        .mask     (mask_q),
        .clr_pend (clr_pend),
        .irq      (irq)
    );

    always_comb begin
        case (reg_addr_e'(bus_addr))
            RA_DIR:                         bus_rdata = dir_q;
            RA_DATA, RA_SET, RA_CLR, RA_TGL: bus_rdata = src;
            RA_MSET, RA_MCLR:               bus_rdata = mask_q;
            RA_TRIG:                        bus_rdata = trig_q;
            RA_BOTH:                        bus_rdata = both_q;
            default:                        bus_rdata = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  mask,
    input logic              irq
);
    logic wr_en;
    assign wr_en = bus_sel && bus_wr;

    a_r1_dir_follows: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr == 4'd0) |=> (pin_oe == $past(bus_wdata)));

    a_r2_set_ones: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr == 4'd2) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    a_r2_hold_out: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && bus_addr >= 4'd1 && bus_addr <= 4'd4) |=> $stable(pin_out));

    a_r3_clr_ones: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr == 4'd3) |=> ((pin_out & $past(bus_wdata)) == '0));

    a_r3_tgl_flip: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr == 4'd4) |=> (pin_out == ($past(pin_out) ^ $past(bus_wdata))));

    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .mask      (mask_q),
    .irq       (irq)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pin_in = '0;
    logic [W-1:0]  pin_out;
    logic [W-1:0]  pin_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_irq_port u_gpio_irq_port (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Behavioural reference state
    bit [W-1:0] m_dir, m_out, m_mask, m_trig, m_both, m_s1, m_s2, m_prev, m_pend;

    function automatic bit [W-1:0] m_source();
        return (m_dir & m_out) | (~m_dir & m_s2);
    endfunction

    function automatic bit m_irq();
        bit [W-1:0] s;
        bit r;
        s = m_source();
        r = 0;
        for (int i = 0; i < W; i++)
            if (m_mask[i] && (m_trig[i] ? m_pend[i] : s[i])) r = 1;
        return r;
    endfunction

    function automatic bit [W-1:0] m_read(input int a);
        case (a)
            0: return m_dir;
            1, 2, 3, 4: return m_source();
            5, 6: return m_mask;
            7: return m_trig;
            8: return m_both;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_dir = 0; m_out = 0; m_mask = 0; m_trig = 0; m_both = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0;
        end else begin
            bit [W-1:0] s, np;
            bit w;
            s  = m_source();
            np = m_pend;
            for (int i = 0; i < W; i++) begin
                if (m_trig[i] && ((s[i] && !m_prev[i]) || (m_both[i] && !s[i] && m_prev[i])))
                    np[i] = 1;
            end
            w = bus_sel && bus_wr;
            if (w && bus_addr == 3) np = np & ~bus_wdata;
            m_prev = s;
            m_s2 = m_s1;
            m_s1 = pin_in;
            if (w) begin
                case (bus_addr)
                    0: m_dir = bus_wdata;
                    1: m_out = bus_wdata;
                    2: m_out = m_out | bus_wdata;
                    3: m_out = m_out & ~bus_wdata;
                    4: m_out = m_out ^ bus_wdata;
                    5: m_mask = m_mask | bus_wdata;
                    6: m_mask = m_mask & ~bus_wdata;
                    7: m_trig = bus_wdata;
                    8: m_both = bus_wdata;
                    default: ;
                endcase
            end
            m_pend = np;
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R1 pin_oe", pin_oe, m_dir);
            check("R2 pin_out", pin_out, m_out);
            check("R11 irq", {15'd0, irq}, {15'd0, m_irq()});
        end
    end

    // Tasks assume entry at posedge+5
    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic wr(input int a, input logic [W-1:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
        @(posedge clk); #5;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input string req, input int a, input logic [W-1:0] exp);
        bus_addr = 4'(a);
        #2;
        check(req, bus_rdata, exp);
        check(req, bus_rdata, m_read(a));
        @(posedge clk); #5;
    endtask

    task automatic expect_irq(input string req, input bit exp);
        check(req, {15'd0, irq}, {15'd0, exp});
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        // Reset state
        rd("R1 reset dir", 0, 16'h0000);
        rd("R5 reset mask", 5, 16'h0000);
        check("R2 reset out", pin_out, 16'h0000);
        expect_irq("R11 reset irq", 0);

        // Direction and strobes
        wr(0, 16'hFF0F);
        check("R1 oe after write", pin_oe, 16'hFF0F);
        wr(2, 16'hA5A5);
        check("R2 set", pin_out, 16'hA5A5);
        wr(2, 16'h0101);
        check("R2 set keeps zeros", pin_out, 16'hA5A5);
        wr(3, 16'h8421);
        check("R3 clear", pin_out, 16'h2184);
        wr(4, 16'hFFFF);
        check("R3 toggle all", pin_out, 16'hDE7B);
        wr(4, 16'h000F);
        check("R3 toggle low", pin_out, 16'hDE74);
        wr(1, 16'h1234);
        check("R4 data write", pin_out, 16'h1234);

        // Data readback mixes outputs and synchronised inputs
        pin_in = 16'h00F0;
        idle(2);
        rd("R4 data read", 1, 16'h12F4);
        rd("R4 set addr read", 2, 16'h12F4);
        rd("R4 toggle addr read", 4, 16'h12F4);

        // Back to all-input, clean state
        wr(0, 16'h0000);
        wr(1, 16'h0000);
        pin_in = 16'h0000;
        idle(3);

        // Mask set/clear
        wr(5, 16'h00FF);
        wr(6, 16'h00F0);
        rd("R5 mask read", 6, 16'h000F);
        wr(6, 16'h000E);

        // Level trigger on pin 0
        pin_in[0] = 1;
        idle(2);
        expect_irq("R6 level high", 1);
        pin_in[0] = 0;
        idle(2);
        expect_irq("R6 level not latched", 0);

        // Rising-only edge on pin 1
        wr(6, 16'h0001);
        wr(7, 16'h0002);
        rd("R6 trig read", 7, 16'h0002);
        wr(5, 16'h0002);
        pin_in[1] = 1;
        idle(3);
        expect_irq("R7 rising latched", 1);
        pin_in[1] = 0;
        idle(3);
        expect_irq("R7 stays pending", 1);
        wr(3, 16'h0002);
        expect_irq("R9 cleared", 0);
        pin_in[1] = 1;
        idle(3);
        wr(3, 16'h0002);
        pin_in[1] = 0;
        idle(3);
        expect_irq("R7 falling ignored", 0);

        // Both edges on pin 1
        wr(8, 16'h0002);
        rd("R8 both read", 8, 16'h0002);
        pin_in[1] = 1;
        idle(3);
        wr(3, 16'h0002);
        pin_in[1] = 0;
        idle(3);
        expect_irq("R8 falling latched", 1);
        wr(3, 16'h0002);

        // Masked pending survives
        wr(6, 16'h0002);
        pin_in[1] = 1;
        idle(3);
        expect_irq("R11 masked", 0);
        wr(5, 16'h0002);
        expect_irq("R11 pending kept", 1);
        wr(3, 16'h0002);

        // Clear coincides with arriving edge: clear wins
        pin_in[1] = 0;
        idle(2);
        wr(3, 16'h0002);
        expect_irq("R9 clear wins", 0);
        idle(2);
        expect_irq("R9 still clear", 0);

        // Output pin triggered by software
        wr(6, 16'hFFFF);
        wr(8, 16'h0000);
        wr(0, 16'h0004);
        wr(7, 16'h0004);
        wr(5, 16'h0004);
        pin_in[2] = 0;
        wr(2, 16'h0004);
        idle(1);
        expect_irq("R10 output edge", 1);
        wr(3, 16'h0004);
        idle(1);
        expect_irq("R10 cleared", 0);
        pin_in[2] = 1;
        idle(3);
        expect_irq("R10 pin ignored", 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule